// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the transfers of a single DMA channel. It holds a byte counter, accepts a software start strobe and peripheral requests, and for every transfer issues one read and then one write on a simple request/acknowledge bus. Each read or write may come back with an error response. Address generation and the bus fabric sit outside it; the block only moves one data word from the read side to the write side per transfer.

Two run styles are selectable. In continuous mode one trigger drains the whole count with back-to-back transfers. In cycle-steal mode every accepted trigger moves exactly one unit. Completion raises a done flag that blocks further triggers until software clears it. Completion can also drop the peripheral request enable and raise a level interrupt. A link output pulses with a target channel number after each transfer or at the end of the count, according to one of four link modes.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the channel is idle: busy, done, every error flag, req_pend, req_en, irq, link_pulse, rd_req and wr_req are 0 and bytes_left is 0.
- R2: When a trigger is taken while bytes_left is 0 or above 0x0F_FFFF, the next clock sets err_cfg and done, no bus request is made and bytes_left keeps its value.
- R3: A transfer holds rd_req until a read acknowledge, then holds wr_req until a write acknowledge; wr_data equals the rd_data captured with the read acknowledge.
- R4: A successful transfer lowers bytes_left by the unit size of xfer_size (1 = 1 byte, 2 = 2 bytes, 0 or 3 = 4 bytes), never below 0.
- R5: With cyc_steal = 0, one trigger starts transfers that follow each other without returning to idle until bytes_left reaches 0; busy stays 1 for the whole run.
- R6: With cyc_steal = 1, each trigger makes exactly one transfer and the channel then returns to idle; a peripheral request seen while req_en is 1 is held in req_pend, also during a transfer, until a transfer starts from it.
- R7: A start strobe, accepted only while idle with done = 0, triggers once and is consumed when the transfer begins; it does not retrigger later.
- R8: done is set when bytes_left reaches 0 or on any error; while done is 1 no trigger starts the channel. A done_clr pulse clears done and all three error flags.
- R9: A read error response sets err_src and done without a write phase; a write error response sets err_dst and done. In both cases bytes_left is unchanged.
- R10: When dis_req_on_done is 1, req_en drops to 0 on the clock that sets done; otherwise req_en changes only through req_en_wr.
- R11: link_pulse is a one-cycle pulse after a successful transfer, with link_ch giving the target. link_mode 1: link_ch_b when the count reaches 0, otherwise link_ch_a after each cycle-steal transfer. Mode 2: link_ch_a after each cycle-steal transfer. Mode 3: link_ch_a when the count reaches 0. Mode 0: never.
- R12: irq is 1 exactly while done and int_en are both 1.
- R13: A count write (cnt_wr) loads bytes_left only while the channel is idle; during a run it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Byte count write strobe |
| cnt_wdata | input | 24 | Byte count value |
| start_wr | input | 1 | Software start strobe |
| req_en_wr | input | 1 | Request-enable write strobe |
| req_en_wdata | input | 1 | Request-enable value |
| done_clr | input | 1 | Clears done and error flags |
| cyc_steal | input | 1 | 1 = one transfer per trigger, 0 = continuous |
| xfer_size | input | 2 | Unit size code |
| dis_req_on_done | input | 1 | Drop req_en when done is set |
| int_en | input | 1 | Interrupt enable |
| link_mode | input | 2 | Link mode 0..3 |
| link_ch_a | input | 4 | First link target channel |
| link_ch_b | input | 4 | End-of-count target in mode 1 |
| periph_req | input | 1 | Peripheral request |
| rd_req | output | 1 | Read request |
| rd_ack | input | 1 | Read acknowledge |
| rd_err | input | 1 | Read error response, valid with rd_ack |
| rd_data | input | 32 | Read data, valid with rd_ack |
| wr_req | output | 1 | Write request |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error response, valid with wr_ack |
| wr_data | output | 32 | Write data |
| busy | output | 1 | Channel running |
| done | output | 1 | Run finished or aborted |
| req_pend | output | 1 | Peripheral request waiting |
| err_src | output | 1 | Read error seen |
| err_dst | output | 1 | Write error seen |
| err_cfg | output | 1 | Bad byte count at start |
| bytes_left | output | 24 | Remaining byte count |
| req_en | output | 1 | Peripheral request enable |
| irq | output | 1 | Interrupt level |
| link_pulse | output | 1 | Link trigger pulse |
| link_ch | output | 4 | Link target channel |

## Verification
A wrong control state shows at the ports on the very next clock. A missed or extra phase changes rd_req or wr_req. A bad decrement changes bytes_left in the cycle after the write acknowledge. A lost pending request or a start that is not consumed shows up as busy rising when it should not, or staying low when it should rise. The bench replays the same inputs through a behavioural model, so any such divergence is reported in the cycle where it first appears, not only when the run ends.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    LNK_NONE         = 2'd0,
    LNK_EACH_AND_END = 2'd1,
    LNK_EACH         = 2'd2,
    LNK_END          = 2'd3
  } link_mode_e;

  // Bytes moved per transfer for a unit size code.
  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_counter.sv
module dma_seq_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic [1:0]       size,
  output logic [CNT_W-1:0] count,
  output logic             after_zero
);
  import dma_seq_pkg::*;

  function automatic logic [CNT_W-1:0] sat_sub(input logic [CNT_W-1:0] c,
                                               input logic [2:0] s);
    logic [CNT_W-1:0] sw;
    sw = {{(CNT_W-3){1'b0}}, s};
    if (c <= sw) return '0;
    return c - sw;
  endfunction

  logic [CNT_W-1:0] count_after;

  assign count_after = sat_sub(count, unit_bytes(size));
  assign after_zero  = (count_after == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count_after;
  end

  // R4: a decrement never raises the count
  a_r4_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (count <= $past(count)));

endmodule

// File: rtl/dma_seq_link.sv
module dma_seq_link #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_ok,
  input  logic            at_zero,
  input  logic            cyc_steal,
  input  logic [1:0]      mode,
  input  logic [CH_W-1:0] ch_a,
  input  logic [CH_W-1:0] ch_b,
  output logic            pulse,
  output logic [CH_W-1:0] ch
);
  import dma_seq_pkg::*;

  logic            hit;
  logic [CH_W-1:0] target;

  always_comb begin
    hit    = 1'b0;
    target = ch_a;
    if (xfer_ok) begin
      case (link_mode_e'(mode))
        LNK_EACH_AND_END: begin
          if (at_zero) begin
            hit    = 1'b1;
            target = ch_b;
          end else if (cyc_steal) begin
            hit = 1'b1;
          end
        end
        LNK_EACH: hit = cyc_steal;
        LNK_END:  hit = at_zero;
        default:  hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      ch    <= '0;
    end else begin
      pulse <= hit;
      if (hit) ch <= target;
    end
  end

  // R11: link output lasts a single cycle
  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl #(
  parameter int          CNT_W   = 24,
  parameter int          DATA_W  = 32,
  parameter int unsigned CNT_MAX = 32'h000F_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              periph_req,
  input  logic              req_en_wr,
  input  logic              req_en_wdata,
  input  logic              done_clr,
  input  logic              cyc_steal,
  input  logic              dis_req_on_done,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  count,
  input  logic              after_zero,
  input  logic              rd_ack,
  input  logic              rd_err,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_ack,
  input  logic              wr_err,
  output logic              rd_req,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data,
  output logic              load,
  output logic              xfer_ok,
  output logic              busy,
  output logic              done,
  output logic              err_src,
  output logic              err_dst,
  output logic              err_cfg,
  output logic              req_pend,
  output logic              req_en
);
  import dma_seq_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

  seq_state_e state, state_n;
  logic start_q;

  // Named internal events
  logic idle, begin_run, cfg_bad, rd_fin, wr_fin, set_done, start_set;

  assign idle      = (state == ST_IDLE);
  assign begin_run = idle && (start_q || req_pend) && !done;
  assign cfg_bad   = (count == '0) || (count > LIMIT);
  assign rd_fin    = (state == ST_READ) && rd_ack;
  assign wr_fin    = (state == ST_WRITE) && wr_ack;
  assign xfer_ok   = wr_fin && !wr_err;
  assign start_set = start_wr && idle && !done;
  assign load      = cnt_wr && idle && !begin_run;
  assign set_done  = (begin_run && cfg_bad) || (rd_fin && rd_err) ||
                     (wr_fin && wr_err) || (xfer_ok && after_zero);

  assign rd_req = (state == ST_READ);
  assign wr_req = (state == ST_WRITE);
  assign busy   = !idle;

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:  if (begin_run && !cfg_bad) state_n = ST_READ;
      ST_READ:  if (rd_ack) state_n = rd_err ? ST_IDLE : ST_WRITE;
      ST_WRITE: if (wr_ack) begin
        if (wr_err || after_zero || cyc_steal) state_n = ST_IDLE;
        else                                   state_n = ST_READ;
      end
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      start_q  <= 1'b0;
      req_pend <= 1'b0;
      req_en   <= 1'b0;
      done     <= 1'b0;
      err_src  <= 1'b0;
      err_dst  <= 1'b0;
      err_cfg  <= 1'b0;
      wr_data  <= '0;
    end else begin
      state <= state_n;
      if (begin_run)      start_q <= 1'b0;
      else if (start_set) start_q <= 1'b1;
      if (periph_req && req_en) req_pend <= 1'b1;
      else if (begin_run)       req_pend <= 1'b0;
      if (req_en_wr) req_en <= req_en_wdata;
      if (set_done && dis_req_on_done) req_en <= 1'b0;
      if (done_clr) begin
        done    <= 1'b0;
        err_src <= 1'b0;
        err_dst <= 1'b0;
        err_cfg <= 1'b0;
      end
      if (set_done) done <= 1'b1;
      if (begin_run && cfg_bad) err_cfg <= 1'b1;
      if (rd_fin && rd_err)     err_src <= 1'b1;
      if (wr_fin && wr_err)     err_dst <= 1'b1;
      if (rd_fin && !rd_err)    wr_data <= rd_data;
    end
  end

  // R2: a configuration error only follows a bad count
  a_r2_cfg_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_cfg) |-> ((count == '0) || (count > LIMIT)));

  // R3: a write phase is always entered from a read phase
  a_r3_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_req));

  // R5: continuous mode goes straight on to the next read
  a_r5_cont_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok && !after_zero && !cyc_steal) |=> rd_req);

  // R8: no start while done is held
  a_r8_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (done && idle && !done_clr) |=> !busy);

  // R9: a read error skips the write phase
  a_r9_rd_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fin && rd_err) |=> (!wr_req && err_src && done));

  // R10: request enable dropped with done
  a_r10_req_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (set_done && dis_req_on_done) |=> !req_en);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int          CNT_W   = 24,
  parameter int          DATA_W  = 32,
  parameter int          CH_W    = 4,
  parameter int unsigned CNT_MAX = 32'h000F_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              start_wr,
  input  logic              req_en_wr,
  input  logic              req_en_wdata,
  input  logic              done_clr,
  input  logic              cyc_steal,
  input  logic [1:0]        xfer_size,
  input  logic              dis_req_on_done,
  input  logic              int_en,
  input  logic [1:0]        link_mode,
  input  logic [CH_W-1:0]   link_ch_a,
  input  logic [CH_W-1:0]   link_ch_b,
  input  logic              periph_req,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic              rd_err,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  input  logic              wr_ack,
  input  logic              wr_err,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              req_pend,
  output logic              err_src,
  output logic              err_dst,
  output logic              err_cfg,
  output logic [CNT_W-1:0]  bytes_left,
  output logic              req_en,
  output logic              irq,
  output logic              link_pulse,
  output logic [CH_W-1:0]   link_ch
);

  logic load, xfer_ok, after_zero;

  dma_seq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (cnt_wdata),
    .dec        (xfer_ok),
    .size       (xfer_size),
    .count      (bytes_left),
    .after_zero (after_zero)
  );

  dma_seq_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CNT_MAX(CNT_MAX)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_wr        (start_wr),
    .periph_req      (periph_req),
    .req_en_wr       (req_en_wr),
    .req_en_wdata    (req_en_wdata),
    .done_clr        (done_clr),
    .cyc_steal       (cyc_steal),
    .dis_req_on_done (dis_req_on_done),
    .cnt_wr          (cnt_wr),
    .count           (bytes_left),
    .after_zero      (after_zero),
    .rd_ack          (rd_ack),
    .rd_err          (rd_err),
    .rd_data         (rd_data),
    .wr_ack          (wr_ack),
    .wr_err          (wr_err),
    .rd_req          (rd_req),
    .wr_req          (wr_req),
    .wr_data         (wr_data),
    .load            (load),
    .xfer_ok         (xfer_ok),
    .busy            (busy),
    .done            (done),
    .err_src         (err_src),
    .err_dst         (err_dst),
    .err_cfg         (err_cfg),
    .req_pend        (req_pend),
    .req_en          (req_en)
  );

  dma_seq_link #(.CH_W(CH_W)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_ok   (xfer_ok),
    .at_zero   (after_zero),
    .cyc_steal (cyc_steal),
    .mode      (link_mode),
    .ch_a      (link_ch_a),
    .ch_b      (link_ch_b),
    .pulse     (link_pulse),
    .ch        (link_ch)
  );

  assign irq = done && int_en;

endmodule

// File: tb/dma_xfer_seq_bench.sv
`timescale 1ns/1ps
module dma_xfer_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_wr = 0, start_wr = 0, req_en_wr = 0, req_en_wdata = 0, done_clr = 0;
  logic [23:0] cnt_wdata = '0;
  logic        cyc_steal = 0, dis_req_on_done = 0, int_en = 0, periph_req = 0;
  logic [1:0]  xfer_size = 0, link_mode = 0;
  logic [3:0]  link_ch_a = 0, link_ch_b = 0;
  logic        rd_ack = 0, rd_err = 0, wr_ack = 0, wr_err = 0;
  logic [31:0] rd_data = '0;
  logic        rd_req, wr_req, busy, done, req_pend, err_src, err_dst, err_cfg;
  logic        req_en, irq, link_pulse;
  logic [31:0] wr_data;
  logic [23:0] bytes_left;
  logic [3:0]  link_ch;

  always #10 clk = ~clk;

  dma_xfer_seq u_dma_xfer_seq (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_st, m_cnt, m_lc;
  bit  m_start, m_pend, m_en, m_done, m_es, m_ed, m_ec, m_lp;
  logic [31:0] m_wd;

  function automatic int step_of(input logic [1:0] s);
    if (s == 2'd1) return 1;
    if (s == 2'd2) return 2;
    return 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lc = 0; m_start = 0; m_pend = 0; m_en = 0;
      m_done = 0; m_es = 0; m_ed = 0; m_ec = 0; m_lp = 0; m_wd = '0;
    end else begin
      bit go, bad, sd, z;
      int n_st, n_cnt;
      go = (m_st == 0) && (m_start || m_pend) && !m_done;
      bad = (m_cnt == 0) || (m_cnt > 32'h0F_FFFF);
      n_st = m_st; n_cnt = m_cnt; sd = 0; m_lp = 0;
      if (done_clr) begin m_done = 0; m_es = 0; m_ed = 0; m_ec = 0; end
      if (go) begin
        if (bad) begin m_ec = 1; sd = 1; end else n_st = 1;
      end
      if (m_st == 1 && rd_ack) begin
        if (rd_err) begin m_es = 1; sd = 1; n_st = 0; end
        else begin m_wd = rd_data; n_st = 2; end
      end
      if (m_st == 2 && wr_ack) begin
        if (wr_err) begin m_ed = 1; sd = 1; n_st = 0; end
        else begin
          n_cnt = (m_cnt <= step_of(xfer_size)) ? 0 : m_cnt - step_of(xfer_size);
          z = (n_cnt == 0);
          if (link_mode == 1) begin
            if (z) begin m_lp = 1; m_lc = link_ch_b; end
            else if (cyc_steal) begin m_lp = 1; m_lc = link_ch_a; end
          end else if (link_mode == 2 && cyc_steal) begin m_lp = 1; m_lc = link_ch_a; end
          else if (link_mode == 3 && z) begin m_lp = 1; m_lc = link_ch_a; end
          if (z) begin sd = 1; n_st = 0; end
          else n_st = cyc_steal ? 0 : 1;
        end
      end
      if (go) m_start = 0;
      else if (start_wr && m_st == 0 && !m_done) m_start = 1;
      if (periph_req && m_en) m_pend = 1;
      else if (go) m_pend = 0;
      if (req_en_wr) m_en = req_en_wdata;
      if (sd && dis_req_on_done) m_en = 0;
      if (sd) m_done = 1;
      if (cnt_wr && m_st == 0 && !go) n_cnt = cnt_wdata;
      m_st = n_st; m_cnt = n_cnt;
    end
  end

  // ---------------- bus responder and per-cycle compare ----------------
  int lat = 0, wcnt = 0, seq = 0, wr_count = 0, link_count = 0;
  bit inj_r = 0, inj_w = 0, cmp_on = 0;

  always @(negedge clk) begin
    rd_ack = 0; wr_ack = 0; rd_err = 0; wr_err = 0;
    if (rst_n && rd_req) begin
      if (wcnt >= lat) begin
        rd_ack = 1; rd_err = inj_r; rd_data = 32'hA500_0000 + seq; seq++; wcnt = 0;
      end else wcnt++;
    end else if (rst_n && wr_req) begin
      if (wcnt >= lat) begin
        wr_ack = 1; wr_err = inj_w; wcnt = 0;
        if (!inj_w) wr_count++;
      end else wcnt++;
    end
    if (link_pulse) link_count++;
    if (cmp_on) begin
      chk("R3 rd_req", rd_req, (m_st == 1));
      chk("R3 wr_req", wr_req, (m_st == 2));
      if (wr_req) chk("R3 wr_data", wr_data, m_wd);
      chk("R5 busy", busy, (m_st != 0));
      chk("R8 done", done, m_done);
      chk("R9 err_src", err_src, m_es);
      chk("R9 err_dst", err_dst, m_ed);
      chk("R2 err_cfg", err_cfg, m_ec);
      chk("R6 req_pend", req_pend, m_pend);
      chk("R4 bytes_left", bytes_left, m_cnt);
      chk("R10 req_en", req_en, m_en);
      chk("R12 irq", irq, m_done && int_en);
      chk("R11 link_pulse", link_pulse, m_lp);
      if (link_pulse) chk("R11 link_ch", link_ch, m_lc);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_count(input logic [23:0] v);
    tick(); cnt_wr = 1; cnt_wdata = v; tick(); cnt_wr = 0;
  endtask

  task automatic pulse_start();
    tick(); start_wr = 1; tick(); start_wr = 0;
  endtask

  task automatic pulse_req();
    tick(); periph_req = 1; tick(); periph_req = 0;
  endtask

  task automatic clear_done();
    tick(); done_clr = 1; tick(); done_clr = 0;
  endtask

  task automatic write_en(input logic v);
    tick(); req_en_wr = 1; req_en_wdata = v; tick(); req_en_wr = 0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) tick();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int w0, l0;
    tick(2);
    // R1: reset state
    chk("R1 busy", busy, 0);   chk("R1 done", done, 0);
    chk("R1 errs", {err_src, err_dst, err_cfg}, 0);
    chk("R1 bytes_left", bytes_left, 0); chk("R1 req_en", req_en, 0);
    chk("R1 irq", irq, 0); chk("R1 link_pulse", link_pulse, 0);
    chk("R1 bus", {rd_req, wr_req}, 0); chk("R1 req_pend", req_pend, 0);
    rst_n = 1; cmp_on = 1;

    // R2: zero count
    w0 = wr_count;
    set_count(0); pulse_start(); wait_done();
    chk("R2 zero count err_cfg", err_cfg, 1);
    chk("R2 no write", wr_count - w0, 0);
    clear_done();
    // R2: oversize count
    set_count(24'h10_0000); pulse_start(); wait_done();
    chk("R2 big count err_cfg", err_cfg, 1);
    chk("R2 count kept", bytes_left, 24'h10_0000);
    clear_done();

    // R5/R13/R12/R11: continuous, 4-byte units, link at end
    lat = 1; int_en = 1; link_mode = 3; link_ch_a = 4'd5;
    w0 = wr_count; l0 = link_count;
    set_count(16); pulse_start(); tick(3);
    cnt_wr = 1; cnt_wdata = 24'd99; tick(); cnt_wr = 0;
    wait_done();
    chk("R13 busy write ignored", bytes_left, 0);
    chk("R5 four transfers", wr_count - w0, 4);
    chk("R12 irq on", irq, 1);
    chk("R11 mode3 one link", link_count - l0, 1);
    clear_done(); int_en = 0; tick();
    chk("R12 irq off", irq, 0);

    // R6/R10/R11: cycle-steal, 1-byte units, mode 1
    cyc_steal = 1; xfer_size = 1; link_mode = 1; link_ch_a = 4'd2; link_ch_b = 4'd7;
    dis_req_on_done = 1; write_en(1); w0 = wr_count; l0 = link_count;
    set_count(3);
    repeat (3) begin pulse_req(); tick(6); end
    chk("R6 three transfers", wr_count - w0, 3);
    chk("R8 done at zero", done, 1);
    chk("R10 req_en dropped", req_en, 0);
    chk("R11 mode1 links", link_count - l0, 3);
    chk("R11 end target", link_ch, 4'd7);
    clear_done(); dis_req_on_done = 0;

    // R4: 2-byte units on odd count, continuous, mode 2 gives no link
    cyc_steal = 0; xfer_size = 2; link_mode = 2; lat = 0;
    w0 = wr_count; l0 = link_count;
    set_count(5); pulse_start(); wait_done();
    chk("R4 odd count transfers", wr_count - w0, 3);
    chk("R4 saturates", bytes_left, 0);
    chk("R11 mode2 continuous none", link_count - l0, 0);
    clear_done();

    // R7: start consumed once in cycle-steal mode
    cyc_steal = 1; xfer_size = 0; link_mode = 0;
    set_count(8); pulse_start(); tick(12);
    chk("R7 idle after one", busy, 0);
    chk("R7 one unit", bytes_left, 4);
    chk("R7 not done", done, 0);
    pulse_start(); wait_done();
    chk("R7 second start", bytes_left, 0);
    clear_done();

    // R9: read error
    cyc_steal = 0; inj_r = 1; w0 = wr_count;
    set_count(8); pulse_start(); wait_done(); inj_r = 0;
    chk("R9 err_src", err_src, 1);
    chk("R9 count kept rd", bytes_left, 8);
    chk("R9 no write", wr_count - w0, 0);
    clear_done();
    // R9: write error
    lat = 2; inj_w = 1;
    pulse_start(); wait_done(); inj_w = 0;
    chk("R9 err_dst", err_dst, 1);
    chk("R9 count kept wr", bytes_left, 8);
    // R8: trigger blocked while done
    pulse_start(); tick(10);
    chk("R8 blocked busy", busy, 0);
    chk("R8 blocked count", bytes_left, 8);
    clear_done(); tick();
    chk("R8 clear done", done, 0);
    chk("R8 clear err", err_dst, 0);
    tick(4);

    // R6: request during a transfer is pended
    cyc_steal = 1; lat = 3; write_en(1); w0 = wr_count;
    pulse_req(); pulse_req(); tick(25);
    chk("R6 pended request served", wr_count - w0, 2);
    chk("R6 count", bytes_left, 0);
    tick(3);
    finish_run();
  end

endmodule